// File: doc/BRIEF.md
# Two-Processor Mailbox Flag Controller

This block lets two processors signal each other through a set of per-channel "occupied" flags. For every channel, each processor owns one flag. A processor raises its own flag to announce that it has posted a message on that channel. The peer lowers that flag to acknowledge that it has taken the message. No payload passes through the block: payloads live in shared memory elsewhere, and the flags only carry the handshake.

Each processor has its own bank of four registers: interrupt enables, per-channel masks, a write-one set/clear register and a status view of its own flags. The bank for processor 1 sits 0x10 above the bank for processor 0. Each processor also gets two level interrupts:
- a receive interrupt, which fires while the peer has an unmasked message waiting;
- a transmit interrupt, which fires while one of its own unmasked channels is free.

Two read-only words report the channel count and the revision. Each processor reaches the whole map through its own synchronous port. Writes take effect at the clock edge, and reads return data combinationally from the current state.

Top module: `mbox_pair_ctrl`

## Requirements
- R1: After reset, all occupied flags read 0, every mask register reads 0xFFFFFFFF, both control registers read 0, and all four interrupt outputs are low.
- R2: Bank b (0 or 1) is at byte offset 0x10*b. Its control word is at +0x0, its mask word at +0x4, its set/clear word at +0x8 and its status word at +0xC. Control reads back only bit 0 (receive enable) and bit 16 (transmit enable). The mask word reads back as written, with bits 15:0 as the receive masks and bits 31:16 as the transmit masks.
- R3: Writing 1 to bit 16+n of bank b's set/clear word sets processor b's own flag for channel n. Bank b's status word shows processor b's flags in bits 15:0, and its upper half reads 0.
- R4: Writing 1 to bit n of bank b's set/clear word clears the other processor's flag for channel n. Zero bits in a set/clear write change nothing.
- R5: rx_irq[b] is high when bank b's receive enable is set and some channel has the other processor's flag set while bank b's receive mask bit for that channel is 0.
- R6: tx_irq[b] is high when bank b's transmit enable is set and some existing channel has processor b's own flag clear while bank b's transmit mask bit for that channel is 0.
- R7: The interrupt outputs are registered. A change to a flag, mask or enable at clock edge k shows on the interrupt outputs at edge k+1.
- R8: Flag bits for channels numbered NUM_CH or higher always read 0, and writes to them are ignored.
- R9: Suppose one processor sets its flag for a channel in the same cycle that the other processor clears that flag. The flag ends up set.
- R10: The word at 0x3F0 reads NUM_CH in bits 7:0. The word at 0x3F4 reads the major revision in bits 7:4 and the minor revision in bits 3:0. Both ignore writes.
- R11: If both ports write the same control or mask word in one cycle, the value from port 1 is kept. Set/clear writes from both ports in one cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| p0_we | input | 1 | Port 0 write strobe |
| p0_addr | input | 10 | Port 0 byte address |
| p0_wdata | input | 32 | Port 0 write data |
| p0_rdata | output | 32 | Port 0 read data (combinational) |
| p1_we | input | 1 | Port 1 write strobe |
| p1_addr | input | 10 | Port 1 byte address |
| p1_wdata | input | 32 | Port 1 write data |
| p1_rdata | output | 32 | Port 1 read data (combinational) |
| rx_irq | output | 2 | Receive interrupt, bit b for processor b |
| tx_irq | output | 2 | Transmit interrupt, bit b for processor b |

## Verification
A wrong flag shows up in a status read on the negative edge right after the write edge. In the same cycle it flips the peer's receive condition or the owner's transmit condition, so the interrupt outputs disagree one edge later. A wrong mask or enable shows in the read-back at once and in the interrupts one edge later. The bench walks every channel, including those beyond NUM_CH, through set and acknowledge from both banks, and predicts all four interrupts from its own model after every step. It checks the interrupt before and after the one-cycle registration, and it tests the simultaneous set-against-clear and write-collision cases.

// File: rtl/mbox_pair_pkg.sv
package mbox_pair_pkg;
    localparam int MAX_CH   = 16;
    localparam int NUM_BANK = 2;
    localparam int ADDR_W   = 10;
    localparam int DATA_W   = 32;

    localparam logic [ADDR_W-1:0] CFG_ADDR = 10'h3F0;
    localparam logic [ADDR_W-1:0] REV_ADDR = 10'h3F4;

    typedef enum logic [1:0] {
        REG_CTRL   = 2'd0,
        REG_MASK   = 2'd1,
        REG_SETCLR = 2'd2,
        REG_STAT   = 2'd3
    } bank_reg_e;

    typedef struct packed {
        logic              rx_en;
        logic              tx_en;
        logic [MAX_CH-1:0] tx_mask;
        logic [MAX_CH-1:0] rx_mask;
        logic              rx_irq;
        logic              tx_irq;
    } proc_state_t;
endpackage

// File: rtl/mbox_occ_flags.sv
module mbox_occ_flags
    import mbox_pair_pkg::*;
#(
    parameter int NUM_CH = 16
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [NUM_BANK-1:0][MAX_CH-1:0]  set_req,
    input  logic [NUM_BANK-1:0][MAX_CH-1:0]  clr_req,
    output logic [NUM_BANK-1:0][MAX_CH-1:0]  occ
);
    localparam logic [MAX_CH-1:0] VALID = MAX_CH'((33'd1 << NUM_CH) - 33'd1);

    typedef struct packed {
        logic [NUM_BANK-1:0][MAX_CH-1:0] occ;
    } flag_state_t;

    flag_state_t st_d, st_q;

    // set is applied after clear, so a same-cycle set survives a clear
    always_comb begin
        st_d = st_q;
        for (int b = 0; b < NUM_BANK; b++) begin
            st_d.occ[b] = ((st_q.occ[b] & ~clr_req[b]) | set_req[b]) & VALID;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign occ = st_q.occ;

    for (genvar gb = 0; gb < NUM_BANK; gb++) begin : g_chk
        p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (|(set_req[gb] & VALID)) |=>
            ((occ[gb] & $past(set_req[gb] & VALID)) == $past(set_req[gb] & VALID)));
        p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (|(clr_req[gb] & ~set_req[gb])) |=>
            ((occ[gb] & $past(clr_req[gb] & ~set_req[gb])) == '0));
        p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (set_req[gb] == '0 && clr_req[gb] == '0) |=> $stable(occ[gb]));
    end
endmodule

// File: rtl/mbox_proc_regs.sv
module mbox_proc_regs
    import mbox_pair_pkg::*;
#(
    parameter int NUM_CH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_we,
    input  logic [DATA_W-1:0] ctrl_wdata,
    input  logic              mask_we,
    input  logic [DATA_W-1:0] mask_wdata,
    input  logic [MAX_CH-1:0] own_occ,
    input  logic [MAX_CH-1:0] peer_occ,
    output logic [DATA_W-1:0] ctrl_rd,
    output logic [DATA_W-1:0] mask_rd,
    output logic              rx_irq,
    output logic              tx_irq
);
    localparam logic [MAX_CH-1:0] VALID = MAX_CH'((33'd1 << NUM_CH) - 33'd1);

    proc_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ctrl_we) begin
            st_d.rx_en = ctrl_wdata[0];
            st_d.tx_en = ctrl_wdata[16];
        end
        if (mask_we) begin
            st_d.rx_mask = mask_wdata[MAX_CH-1:0];
            st_d.tx_mask = mask_wdata[2*MAX_CH-1:MAX_CH];
        end
        st_d.rx_irq = st_q.rx_en && (|(peer_occ & ~st_q.rx_mask & VALID));
        st_d.tx_irq = st_q.tx_en && (|(~own_occ & ~st_q.tx_mask & VALID));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q         <= '0;
            st_q.rx_mask <= '1;
            st_q.tx_mask <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctrl_rd = {15'b0, st_q.tx_en, 15'b0, st_q.rx_en};
    assign mask_rd = {st_q.tx_mask, st_q.rx_mask};
    assign rx_irq  = st_q.rx_irq;
    assign tx_irq  = st_q.tx_irq;

    p_rx_needs_en_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |-> $past(st_q.rx_en));
    p_tx_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.tx_en |=> !tx_irq);
    p_rx_masked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.rx_mask == '1) |=> !rx_irq);
    p_tx_all_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((own_occ & VALID) == VALID) |=> !tx_irq);
endmodule

// File: rtl/mbox_pair_ctrl.sv
module mbox_pair_ctrl
    import mbox_pair_pkg::*;
#(
    parameter int         NUM_CH    = 16,
    parameter logic [3:0] REV_MAJOR = 4'd1,
    parameter logic [3:0] REV_MINOR = 4'd0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              p0_we,
    input  logic [ADDR_W-1:0] p0_addr,
    input  logic [DATA_W-1:0] p0_wdata,
    output logic [DATA_W-1:0] p0_rdata,
    input  logic              p1_we,
    input  logic [ADDR_W-1:0] p1_addr,
    input  logic [DATA_W-1:0] p1_wdata,
    output logic [DATA_W-1:0] p1_rdata,
    output logic [1:0]        rx_irq,
    output logic [1:0]        tx_irq
);
    localparam int NPORT = 2;

    logic [NPORT-1:0]                  we;
    logic [NPORT-1:0][ADDR_W-1:0]      addr;
    logic [NPORT-1:0][DATA_W-1:0]      wdata;
    logic [NPORT-1:0][DATA_W-1:0]      rdata;

    logic [NUM_BANK-1:0][MAX_CH-1:0]   set_req, clr_req, occ;
    logic [NUM_BANK-1:0]               ctrl_we, mask_we;
    logic [NUM_BANK-1:0][DATA_W-1:0]   ctrl_wd, mask_wd, ctrl_rd, mask_rd;

    assign we    = {p1_we, p0_we};
    assign addr  = {p1_addr, p0_addr};
    assign wdata = {p1_wdata, p0_wdata};

    function automatic logic bank_hit(input logic [ADDR_W-1:0] a);
        return (a[ADDR_W-1:5] == '0) && (a[1:0] == 2'b00);
    endfunction

    // write decode; later port overrides earlier for control/mask
    always_comb begin
        set_req = '0;
        clr_req = '0;
        ctrl_we = '0;
        mask_we = '0;
        ctrl_wd = '0;
        mask_wd = '0;
        for (int p = 0; p < NPORT; p++) begin
            if (we[p] && bank_hit(addr[p])) begin
                case (bank_reg_e'(addr[p][3:2]))
                    REG_CTRL: begin
                        ctrl_we[addr[p][4]] = 1'b1;
                        ctrl_wd[addr[p][4]] = wdata[p];
                    end
                    REG_MASK: begin
                        mask_we[addr[p][4]] = 1'b1;
                        mask_wd[addr[p][4]] = wdata[p];
                    end
                    REG_SETCLR: begin
                        set_req[addr[p][4]]  = set_req[addr[p][4]]  | wdata[p][2*MAX_CH-1:MAX_CH];
                        clr_req[!addr[p][4]] = clr_req[!addr[p][4]] | wdata[p][MAX_CH-1:0];
                    end
                    default: ;
                endcase
            end
        end
    end

    mbox_occ_flags #(.NUM_CH(NUM_CH)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_req (set_req),
        .clr_req (clr_req),
        .occ     (occ)
    );

    for (genvar gb = 0; gb < NUM_BANK; gb++) begin : g_bank
        mbox_proc_regs #(.NUM_CH(NUM_CH)) u_regs (
            .clk        (clk),
            .rst_n      (rst_n),
            .ctrl_we    (ctrl_we[gb]),
            .ctrl_wdata (ctrl_wd[gb]),
            .mask_we    (mask_we[gb]),
            .mask_wdata (mask_wd[gb]),
            .own_occ    (occ[gb]),
            .peer_occ   (occ[NUM_BANK-1-gb]),
            .ctrl_rd    (ctrl_rd[gb]),
            .mask_rd    (mask_rd[gb]),
            .rx_irq     (rx_irq[gb]),
            .tx_irq     (tx_irq[gb])
        );
    end

    always_comb begin
        for (int p = 0; p < NPORT; p++) begin
            rdata[p] = '0;
            if (bank_hit(addr[p])) begin
                case (bank_reg_e'(addr[p][3:2]))
                    REG_CTRL: rdata[p] = ctrl_rd[addr[p][4]];
                    REG_MASK: rdata[p] = mask_rd[addr[p][4]];
                    REG_STAT: rdata[p] = {{(DATA_W-MAX_CH){1'b0}}, occ[addr[p][4]]};
                    default:  rdata[p] = '0;
                endcase
            end else if (addr[p] == CFG_ADDR) begin
                rdata[p] = DATA_W'(NUM_CH);
            end else if (addr[p] == REV_ADDR) begin
                rdata[p] = {24'b0, REV_MAJOR, REV_MINOR};
            end
        end
    end

    assign p0_rdata = rdata[0];
    assign p1_rdata = rdata[1];

    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (rx_irq == 2'b00 && tx_irq == 2'b00));
endmodule

// File: tb/test_mbox_pair_ctrl.sv
module test_mbox_pair_ctrl;
    localparam int NCH = 6;
    localparam logic [15:0] VALID = 16'h003F;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        p0_we = 1'b0, p1_we = 1'b0;
    logic [9:0]  p0_addr = '0, p1_addr = '0;
    logic [31:0] p0_wdata = '0, p1_wdata = '0;
    logic [31:0] p0_rdata, p1_rdata;
    logic [1:0]  rx_irq, tx_irq;

    int n_chk = 0;
    int n_fail = 0;

    logic [15:0] m_occ [2];
    logic [15:0] m_rxm [2];
    logic [15:0] m_txm [2];
    logic        m_rxen [2];
    logic        m_txen [2];

    always #2 clk = ~clk;

    mbox_pair_ctrl #(.NUM_CH(NCH)) i_mbox_pair_ctrl (
        .clk(clk), .rst_n(rst_n),
        .p0_we(p0_we), .p0_addr(p0_addr), .p0_wdata(p0_wdata), .p0_rdata(p0_rdata),
        .p1_we(p1_we), .p1_addr(p1_addr), .p1_wdata(p1_wdata), .p1_rdata(p1_rdata),
        .rx_irq(rx_irq), .tx_irq(tx_irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic void apply(input logic [9:0] a, input logic [31:0] d);
        int b;
        if (a[9:5] == 0 && a[1:0] == 0) begin
            b = int'(a[4]);
            case (a[3:2])
                2'd0: begin m_rxen[b] = d[0]; m_txen[b] = d[16]; end
                2'd1: begin m_rxm[b] = d[15:0]; m_txm[b] = d[31:16]; end
                2'd2: begin
                    m_occ[1-b] = m_occ[1-b] & ~d[15:0];
                    m_occ[b]   = m_occ[b] | (d[31:16] & VALID);
                end
                default: ;
            endcase
        end
    endfunction

    task automatic wr(input int p, input logic [9:0] a, input logic [31:0] d);
        @(negedge clk);
        if (p == 0) begin p0_we = 1'b1; p0_addr = a; p0_wdata = d; end
        else        begin p1_we = 1'b1; p1_addr = a; p1_wdata = d; end
        @(negedge clk);
        p0_we = 1'b0; p1_we = 1'b0;
        apply(a, d);
    endtask

    task automatic rd(input logic [9:0] a, output logic [31:0] d);
        p0_addr = a;
        #1;
        d = p0_rdata;
    endtask

    function automatic logic [1:0] exp_rx();
        for (int p = 0; p < 2; p++)
            exp_rx[p] = m_rxen[p] && (|(m_occ[1-p] & ~m_rxm[p] & VALID));
    endfunction

    function automatic logic [1:0] exp_tx();
        for (int p = 0; p < 2; p++)
            exp_tx[p] = m_txen[p] && (|(~m_occ[p] & ~m_txm[p] & VALID));
    endfunction

    // waits one edge so the registered interrupts settle (R7)
    task automatic check_all(input string req);
        logic [31:0] v;
        @(negedge clk);
        rd(10'h00C, v); chk({req, " R3 status bank0"}, v, {16'b0, m_occ[0]});
        rd(10'h01C, v); chk({req, " R3 status bank1"}, v, {16'b0, m_occ[1]});
        chk({req, " R5 rx_irq"}, {30'b0, rx_irq}, {30'b0, exp_rx()});
        chk({req, " R6 tx_irq"}, {30'b0, tx_irq}, {30'b0, exp_tx()});
    endtask

    initial begin
        #400000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v;
        for (int b = 0; b < 2; b++) begin
            m_occ[b] = '0; m_rxm[b] = '1; m_txm[b] = '1; m_rxen[b] = 0; m_txen[b] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int b = 0; b < 2; b++) begin
            rd(10'(b * 16 + 0), v);  chk("R1 ctrl reset", v, 32'h0);
            rd(10'(b * 16 + 4), v);  chk("R1 mask reset", v, 32'hFFFF_FFFF);
            rd(10'(b * 16 + 12), v); chk("R1 status reset", v, 32'h0);
        end
        chk("R1 irqs reset", {28'b0, rx_irq, tx_irq}, 32'h0);

        // R10 configuration and revision, writes ignored
        rd(10'h3F0, v); chk("R10 config", v, 32'd6);
        rd(10'h3F4, v); chk("R10 revision", v, 32'h10);
        wr(0, 10'h3F0, 32'hFFFF_FFFF);
        rd(10'h3F0, v); chk("R10 config after write", v, 32'd6);

        // R2 control/mask readback
        wr(0, 10'h000, 32'hFFFF_FFFF);
        rd(10'h000, v); chk("R2 ctrl bank0 readback", v, 32'h0001_0001);
        wr(1, 10'h010, 32'h0001_0001);
        wr(0, 10'h004, 32'h1234_5678);
        rd(10'h004, v); chk("R2 mask bank0 readback", v, 32'h1234_5678);
        wr(0, 10'h004, 32'h0);
        wr(1, 10'h014, 32'h0);
        rd(10'h014, v); chk("R2 mask bank1 readback", v, 32'h0);
        check_all("R6 all free");

        // R3/R4/R5/R6/R8 sweep of every channel, both owners
        for (int b = 0; b < 2; b++) begin
            for (int n = 0; n < 16; n++) begin
                wr(b, 10'(b * 16 + 8), 32'(1) << (16 + n));
                check_all("R3 R8 set sweep");
            end
            for (int n = 0; n < 16; n++) begin
                wr(1 - b, 10'((1 - b) * 16 + 8), 32'(1) << n);
                check_all("R4 ack sweep");
            end
        end

        // R4 zero writes change nothing
        wr(0, 10'h008, 32'h0005_0000);
        wr(1, 10'h018, 32'h0000_0000);
        wr(0, 10'h008, 32'h0000_0000);
        check_all("R4 zero write");

        // R7 timing of a mask change: bank1 sees bank0's flags 0 and 2
        wr(1, 10'h014, 32'h0000_0001);
        chk("R7 rx before settle", {31'b0, rx_irq[1]}, 32'd1);
        @(negedge clk);
        chk("R7 rx still on (ch2)", {31'b0, rx_irq[1]}, 32'd1);
        wr(1, 10'h014, 32'h0000_0005);
        chk("R7 rx holds one edge", {31'b0, rx_irq[1]}, 32'd1);
        @(negedge clk);
        chk("R7 rx dropped", {31'b0, rx_irq[1]}, 32'd0);
        wr(1, 10'h014, 32'h0000_0000);
        chk("R7 rx still low one edge", {31'b0, rx_irq[1]}, 32'd0);
        @(negedge clk);
        chk("R7 rx raised", {31'b0, rx_irq[1]}, 32'd1);

        // R5 receive disable
        wr(1, 10'h010, 32'h0001_0000);
        check_all("R5 rx disabled");

        // R9 set against clear, flag clear then set beforehand
        for (int k = 0; k < 2; k++) begin
            @(negedge clk);
            p0_we = 1'b1; p0_addr = 10'h008; p0_wdata = 32'h0008_0000;
            p1_we = 1'b1; p1_addr = 10'h018; p1_wdata = 32'h0000_0008;
            @(negedge clk);
            p0_we = 1'b0; p1_we = 1'b0;
            m_occ[0] = m_occ[0] | 16'h0008;
            rd(10'h00C, v);
            chk("R9 set wins", {31'b0, v[3]}, 32'd1);
            check_all("R9 state");
        end

        // R11 collision on the same mask word, and merged set/clear
        @(negedge clk);
        p0_we = 1'b1; p0_addr = 10'h004; p0_wdata = 32'h0000_00FF;
        p1_we = 1'b1; p1_addr = 10'h004; p1_wdata = 32'h0000_0F00;
        @(negedge clk);
        p0_we = 1'b0; p1_we = 1'b0;
        m_rxm[0] = 16'h0F00; m_txm[0] = 16'h0000;
        rd(10'h004, v); chk("R11 port1 wins mask", v, 32'h0000_0F00);
        @(negedge clk);
        p0_we = 1'b1; p0_addr = 10'h008; p0_wdata = 32'h0020_0000;
        p1_we = 1'b1; p1_addr = 10'h018; p1_wdata = 32'h0010_0000;
        @(negedge clk);
        p0_we = 1'b0; p1_we = 1'b0;
        m_occ[0] = m_occ[0] | 16'h0020;
        m_occ[1] = m_occ[1] | 16'h0010;
        check_all("R11 merged set/clear");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule